// File: doc/BRIEF.md
# Weight-Stationary INT8 Systolic Matrix Engine

This block multiplies streamed activation vectors by a square weight matrix held inside a grid of N×N multiply-accumulate cells. Weight rows are first pushed into a small on-block row queue. While the load mode input is high, the queue drains into the grid one row per clock. The first row of a pass lands in grid row 0, the next in grid row 1, and so on. Once loaded, the weights stay in the cells for as many activation vectors as the user streams.

In compute mode, each accepted activation vector enters the left edge with a diagonal skew: lane i is held back i clocks. Activations step one cell to the right per clock. Partial sums step one cell down per clock, and every cell adds its own product. Column sums leave the bottom edge staggered in time. A de-skew stage lines them up, so that one registered result vector with all N lanes appears in a single cycle. With an unbroken input stream, one result vector comes out every clock and N² multiply-accumulates are in progress.

Top module: `ws_systolic_array`

## Requirements
- R1: With weight matrix W loaded, an accepted vector a (lane i at `a_vec[8i+7:8i]`) produces `r_vec[32j+31:32j]` = Σ_i a_i·W[i][j].
- R2: Operands are two's-complement signed 8-bit values. Sums are exact signed 32-bit values, including −128 and 127 operands in every lane.
- R3: `r_valid` is high for one cycle exactly 2N−1 clock cycles after the edge that accepts the vector (7 at N=4). All N lanes of that result appear in that same cycle.
- R4: Vectors accepted on consecutive cycles give results on consecutive cycles, in acceptance order.
- R5: Weight loading obeys these rules:
  - Grid rows are written only from rows popped out of the queue while `mode_load` is high.
  - Queue rows leave in push order. The first row of a pass becomes grid row 0, the row that multiplies lane 0 of `a_vec`.
  - Lane j of a weight row (`w_row[8j+7:8j]`) feeds output column j.
  - `w_done` is 1 after the N-th row of a pass is written. It is 0 after the other rows of the pass.
- R6: Loaded weights persist unchanged over any number of activation vectors. A later full load pass replaces them.
- R7: `a_ready` equals the inverse of `mode_load` one clock later. An `a_vec` presented while `a_ready` is low is ignored and gives no result.
- R8: The weight queue holds WFIFO_DEPTH rows (default 8). When it is full, `w_ready` is low and a pushed row is dropped.
- R9: Idle cycles between vectors leave `r_valid` low in the matching output cycles and do not alter later results.
- R10: Reset behaviour:
  - While reset is asserted, `r_valid`, `w_done` and `a_ready` are low and `w_ready` is high.
  - All weights reset to zero, so every result is zero until weights are loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_load | input | 1 | 1 = weight load phase, 0 = compute phase |
| w_valid | input | 1 | Weight row offered |
| w_row | input | N*8 | Weight row, lane j for column j |
| w_ready | output | 1 | Weight queue can take a row |
| w_done | output | 1 | Last row of a load pass has been written |
| a_valid | input | 1 | Activation vector offered |
| a_vec | input | N*8 | Activation vector, lane i for grid row i |
| a_ready | output | 1 | Activation vectors accepted (compute phase) |
| r_valid | output | 1 | Result vector valid |
| r_vec | output | N*32 | Result vector, lane j is column j sum |

## Verification
The weight patterns are non-symmetric with distinct entries, so swapping rows and columns or misrouting lanes shows up as a wrong sum. Reset-value weights show that the grid starts from zero. Back-to-back streams of pseudo-random vectors test throughput and ordering, and they show whether the skew and de-skew line up the right diagonal. Vectors of all 127 and all −128 show whether sign extension and 32-bit accumulation are exact. Sparse vectors with gaps separate genuine results from stale pipeline contents. A queue filled to capacity and then pushed once more, followed by an extra empty load phase, shows whether a dropped row or a late pop corrupts the weights.

// File: rtl/sa_pkg.sv
package sa_pkg;
  localparam int ACT_W = 8;
  localparam int ACC_W = 32;
  typedef logic signed [ACT_W-1:0] act_t;
  typedef logic signed [ACC_W-1:0] acc_t;
endpackage

// File: rtl/sa_wfifo.sv
// Row queue for weights; memory written/read synchronously so it maps to block RAM.
module sa_wfifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  output logic             can_push,
  input  logic             pop_req,
  output logic [WIDTH-1:0] dout,
  output logic             dout_vld
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wptr, rptr;
  logic [CW-1:0]    count;
  logic             do_push, do_pop;

  assign can_push = (count != CW'(DEPTH));
  assign do_push  = push && can_push;
  assign do_pop   = pop_req && (count != '0);

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
    if (do_pop)  dout <= mem[rptr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr     <= '0;
      rptr     <= '0;
      count    <= '0;
      dout_vld <= 1'b0;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      dout_vld <= do_pop;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/sa_tapline.sv
// Delay line: tap k presents din delayed by SKEW+k clocks.
module sa_tapline #(
  parameter int W    = 8,
  parameter int SKEW = 0,
  parameter int TAPS = 1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [W-1:0]    din,
  output logic [TAPS*W-1:0] taps
);
  localparam int STAGES = SKEW + TAPS - 1;

  generate
    if (STAGES > 0) begin : g_chain
      logic [W-1:0] stg [STAGES];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int k = 0; k < STAGES; k++) stg[k] <= '0;
        end else begin
          stg[0] <= din;
          for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
      end
    end

    for (genvar gk = 0; gk < TAPS; gk++) begin : g_tap
      if (SKEW + gk == 0) begin : g_direct
        assign taps[gk*W +: W] = din;
      end else begin : g_delayed
        assign taps[gk*W +: W] = g_chain.stg[SKEW+gk-1];
      end
    end
  endgenerate
endmodule

// File: rtl/sa_cell.sv
// One grid cell: holds a weight, adds its product to the sum from above.
module sa_cell
  import sa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic w_we,
  input  act_t w_d,
  input  act_t a_in,
  input  acc_t ps_in,
  output acc_t ps_out
);
  act_t w_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_q    <= '0;
      ps_out <= '0;
    end else begin
      if (w_we) w_q <= w_d;
      ps_out <= ps_in + acc_t'(a_in) * acc_t'(w_q);
    end
  end
endmodule

// File: rtl/ws_systolic_array.sv
module ws_systolic_array
  import sa_pkg::*;
#(
  parameter int N           = 4,
  parameter int WFIFO_DEPTH = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_load,
  input  logic               w_valid,
  input  logic [N*ACT_W-1:0] w_row,
  output logic               w_ready,
  output logic               w_done,
  input  logic               a_valid,
  input  logic [N*ACT_W-1:0] a_vec,
  output logic               a_ready,
  output logic               r_valid,
  output logic [N*ACC_W-1:0] r_vec
);
  localparam int LAT   = 2 * N - 1;
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  // ---------------- weight preload path ----------------
  logic               w_push;
  logic [N*ACT_W-1:0] wf_dout;
  logic               wf_dvld;
  logic [IDX_W-1:0]   row_idx;
  logic [N-1:0]       row_we;

  assign w_push = w_valid && w_ready;

  sa_wfifo #(.WIDTH(N*ACT_W), .DEPTH(WFIFO_DEPTH)) u_wfifo (
    .clk      (clk),
    .rst      (rst),
    .push     (w_push),
    .din      (w_row),
    .can_push (w_ready),
    .pop_req  (mode_load),
    .dout     (wf_dout),
    .dout_vld (wf_dvld)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      row_idx <= '0;
      w_done  <= 1'b0;
    end else if (wf_dvld) begin
      w_done  <= (row_idx == IDX_W'(N - 1));
      row_idx <= (row_idx == IDX_W'(N - 1)) ? '0 : row_idx + 1'b1;
    end
  end

  always_comb begin
    for (int r = 0; r < N; r++) row_we[r] = wf_dvld && (row_idx == IDX_W'(r));
  end

  // ---------------- activation intake ----------------
  logic a_fire;
  act_t feed [N];

  always_ff @(posedge clk) begin
    if (rst) a_ready <= 1'b0;
    else     a_ready <= !mode_load;
  end

  assign a_fire = a_valid && a_ready;

  always_comb begin
    for (int i = 0; i < N; i++) feed[i] = a_fire ? act_t'(a_vec[i*ACT_W +: ACT_W]) : '0;
  end

  // ---------------- cell grid ----------------
  acc_t ps [N][N];

  generate
    for (genvar gi = 0; gi < N; gi++) begin : g_row
      logic [N*ACT_W-1:0] row_taps;

      sa_tapline #(.W(ACT_W), .SKEW(gi), .TAPS(N)) u_skew (
        .clk  (clk),
        .rst  (rst),
        .din  (feed[gi]),
        .taps (row_taps)
      );

      for (genvar gj = 0; gj < N; gj++) begin : g_col
        acc_t ps_in_w;
        if (gi == 0) begin : g_top
          assign ps_in_w = '0;
        end else begin : g_below
          assign ps_in_w = ps[gi-1][gj];
        end

        sa_cell u_cell (
          .clk    (clk),
          .rst    (rst),
          .w_we   (row_we[gi]),
          .w_d    (wf_dout[gj*ACT_W +: ACT_W]),
          .a_in   (row_taps[gj*ACT_W +: ACT_W]),
          .ps_in  (ps_in_w),
          .ps_out (ps[gi][gj])
        );
      end
    end
  endgenerate

  // ---------------- de-skew of column sums ----------------
  logic [N*ACC_W-1:0] col_out;

  generate
    for (genvar gj = 0; gj < N; gj++) begin : g_dsk
      logic [ACC_W-1:0] dsk;
      sa_tapline #(.W(ACC_W), .SKEW(N-1-gj), .TAPS(1)) u_dsk (
        .clk  (clk),
        .rst  (rst),
        .din  (ps[N-1][gj]),
        .taps (dsk)
      );
      assign col_out[gj*ACC_W +: ACC_W] = dsk;
    end
  endgenerate

  // ---------------- valid tracking and output register ----------------
  logic [LAT-1:0] vpipe;

  always_ff @(posedge clk) begin
    if (rst) begin
      vpipe   <= '0;
      r_valid <= 1'b0;
      r_vec   <= '0;
    end else begin
      vpipe[0] <= a_fire;
      for (int k = 1; k < LAT; k++) vpipe[k] <= vpipe[k-1];
      r_valid <= vpipe[LAT-1];
      r_vec   <= col_out;
    end
  end
endmodule

// File: rtl/sa_checker.sv
module sa_checker #(
  parameter int N = 4
) (
  input logic clk,
  input logic rst,
  input logic mode_load,
  input logic a_valid,
  input logic a_ready,
  input logic w_done,
  input logic r_valid
);
  localparam int CAP = 2 * N;

  logic [15:0] inflight;

  always_ff @(posedge clk) begin
    if (rst) inflight <= '0;
    else     inflight <= inflight + 16'(a_valid && a_ready) - 16'(r_valid);
  end

  // R7: load phase closes the activation port one clock later
  p_ready_drop_r7: assert property (@(posedge clk) disable iff (rst)
    mode_load |=> !a_ready);

  // R7: compute phase opens it one clock later
  p_ready_rise_r7: assert property (@(posedge clk) disable iff (rst)
    !mode_load |=> a_ready);

  // R5: a completed pass stems from a pop made during the load phase
  p_done_source_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(w_done) |-> $past(mode_load, 2));

  // R3: every result is owed to an earlier accepted vector
  p_result_owed_r3: assert property (@(posedge clk) disable iff (rst)
    r_valid |-> (inflight != 16'd0));

  // R4: no more vectors in flight than the pipeline can hold
  p_inflight_cap_r4: assert property (@(posedge clk) disable iff (rst)
    inflight <= 16'(CAP));
endmodule

bind ws_systolic_array sa_checker #(.N(N)) u_sa_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_load (mode_load),
  .a_valid   (a_valid),
  .a_ready   (a_ready),
  .w_done    (w_done),
  .r_valid   (r_valid)
);

// File: tb/tb_ws_systolic_array.sv
module tb_ws_systolic_array;
  localparam int N   = 4;
  localparam int FD  = 8;
  localparam int LAT = 2 * N - 1;

  typedef int mat_t [N][N];

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode_load = 1'b0;
  logic w_valid = 1'b0;
  logic a_valid = 1'b0;
  logic [N*8-1:0]  w_row = '0;
  logic [N*8-1:0]  a_vec = '0;
  logic            w_ready, w_done, a_ready, r_valid;
  logic [N*32-1:0] r_vec;

  ws_systolic_array #(.N(N), .WFIFO_DEPTH(FD)) dut (
    .clk(clk), .rst(rst), .mode_load(mode_load),
    .w_valid(w_valid), .w_row(w_row), .w_ready(w_ready), .w_done(w_done),
    .a_valid(a_valid), .a_vec(a_vec), .a_ready(a_ready),
    .r_valid(r_valid), .r_vec(r_vec)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  int seed = 32'h1d2c3b4a;

  mat_t Wm, W1, W2, W3;
  logic [N*32-1:0] exp_q[$];
  int              exp_t[$];
  logic [N*32-1:0] mon_e;
  int              mon_t;

  task automatic chk(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  function automatic logic [N*32-1:0] model(input logic [N*8-1:0] v);
    logic [N*32-1:0] res;
    for (int j = 0; j < N; j++) begin
      int s = 0;
      for (int i = 0; i < N; i++) s += int'($signed(v[i*8 +: 8])) * Wm[i][j];
      res[j*32 +: 32] = s;
    end
    return res;
  endfunction

  function automatic logic [N*8-1:0] pack_row(input mat_t m, input int r);
    logic [N*8-1:0] v;
    for (int j = 0; j < N; j++) v[j*8 +: 8] = 8'(m[r][j]);
    return v;
  endfunction

  function automatic logic [N*8-1:0] rand_vec();
    logic [N*8-1:0] v;
    for (int i = 0; i < N; i++) begin
      seed = seed * 1103515245 + 12345;
      v[i*8 +: 8] = seed[23:16];
    end
    return v;
  endfunction

  // driver: offers one vector; records the expectation only if it will be taken
  task automatic send(input logic [N*8-1:0] v);
    @(negedge clk);
    a_vec   = v;
    a_valid = 1'b1;
    if (a_ready) begin
      exp_q.push_back(model(v));
      exp_t.push_back(cyc + LAT + 1);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      a_valid = 1'b0;
      w_valid = 1'b0;
    end
  endtask

  task automatic push_matrix(input mat_t m);
    for (int r = 0; r < N; r++) begin
      @(negedge clk);
      a_valid = 1'b0;
      w_valid = 1'b1;
      w_row   = pack_row(m, r);
    end
  endtask

  task automatic stream(input int n);
    for (int k = 0; k < n; k++) send(rand_vec());
  endtask

  task automatic drain(input string tag);
    idle(LAT + 3);
    chk(exp_q.size() == 0, $sformatf("%s pending results: got %0d expected 0", tag, exp_q.size()));
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      if (r_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, $sformatf("R7/R9 unexpected r_valid at cycle %0d: got 1 expected 0", cyc));
        end else begin
          mon_e = exp_q.pop_front();
          mon_t = exp_t.pop_front();
          chk(mon_t == cyc, $sformatf("R3 result timing: got cycle %0d expected %0d", cyc, mon_t));
          chk(r_vec == mon_e, $sformatf("R1/R2 result: got %h expected %h", r_vec, mon_e));
        end
      end else if (exp_t.size() > 0 && exp_t[0] <= cyc) begin
        chk(1'b0, $sformatf("R3 missing result at cycle %0d: got r_valid 0 expected 1", cyc));
        void'(exp_q.pop_front());
        void'(exp_t.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected end of sequence");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        Wm[i][j] = 0;
        W1[i][j] = (i * N + j) * 9 - 70;
        W2[i][j] = 3 * i - 5 * j + 1;
        W3[i][j] = (j == 0) ? -128 : ((j % 2 == 1) ? (i + 1) * (j + 2) : -(i + 1) * (j + 2));
      end
    W1[0][0]     = -128;
    W1[N-1][N-1] = 127;

    // R10: reset state
    repeat (3) @(negedge clk);
    chk(r_valid == 1'b0, $sformatf("R10 r_valid in reset: got %0b expected 0", r_valid));
    chk(w_done == 1'b0,  $sformatf("R10 w_done in reset: got %0b expected 0", w_done));
    chk(a_ready == 1'b0, $sformatf("R10 a_ready in reset: got %0b expected 0", a_ready));
    chk(w_ready == 1'b1, $sformatf("R10 w_ready in reset: got %0b expected 1", w_ready));
    rst = 1'b0;
    @(negedge clk);
    chk(a_ready == 1'b1, $sformatf("R7 a_ready in compute phase: got %0b expected 1", a_ready));

    // R10: zero weights give zero results
    send(rand_vec());
    send(rand_vec());
    drain("R10");

    // R7: load phase closes the port, offered vectors are ignored
    @(negedge clk);
    mode_load = 1'b1;
    @(negedge clk);
    chk(a_ready == 1'b0, $sformatf("R7 a_ready in load phase: got %0b expected 0", a_ready));
    send(rand_vec());
    send(rand_vec());
    idle(1);

    // R5: load W1 row by row
    push_matrix(W1);
    idle(4);
    chk(w_done == 1'b1, $sformatf("R5 w_done after full pass: got %0b expected 1", w_done));
    mode_load = 1'b0;
    Wm = W1;
    idle(1);
    chk(a_ready == 1'b1, $sformatf("R7 a_ready back in compute: got %0b expected 1", a_ready));
    chk(exp_q.size() == 0, $sformatf("R7 ignored vectors queued: got %0d expected 0", exp_q.size()));

    // R2/R4: extremes then back-to-back stream
    send({N{8'h7f}});
    send({N{8'h80}});
    stream(8);
    drain("R4");

    // R9: gaps between vectors
    send(rand_vec());
    idle(1);
    send({N{8'h80}});
    idle(3);
    send(rand_vec());
    idle(2);
    send(rand_vec());
    drain("R9");

    // R6: held weights over a long run
    stream(20);
    drain("R6");

    // R8: fill queue with W2 then W3, overflow push dropped
    push_matrix(W2);
    push_matrix(W3);
    @(negedge clk);
    chk(w_ready == 1'b0, $sformatf("R8 w_ready with full queue: got %0b expected 0", w_ready));
    w_valid = 1'b1;
    w_row   = {N{8'h55}};
    idle(1);
    mode_load = 1'b1;
    idle(14);
    chk(w_ready == 1'b1, $sformatf("R8 w_ready after drain: got %0b expected 1", w_ready));
    chk(w_done == 1'b1,  $sformatf("R5 w_done after two passes: got %0b expected 1", w_done));
    mode_load = 1'b0;
    Wm = W3;   // R5/R6: last pass replaces earlier weights
    idle(2);
    send({N{8'h80}});
    stream(5);
    drain("R5");

    // R8: extra load phase with empty queue must not alter weights
    @(negedge clk);
    mode_load = 1'b1;
    idle(6);
    chk(w_done == 1'b1, $sformatf("R8 w_done after empty load phase: got %0b expected 1", w_done));
    mode_load = 1'b0;
    idle(2);
    stream(4);
    drain("R8");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule